// File: doc/BRIEF.md
# Audio Hold and Auto-Mute Controller

This block sits in a stereo DAC datapath, just ahead of interpolation. It guards the analog output when the upstream source flags its data as invalid. While the hold input is active, the block keeps sending the last good left/right pair to the output and throws away whatever arrives on its sample inputs. A hold that lasts too long can silence the output automatically. When the hold ends, the output either resumes by itself or stays silent until software cycles the mute control.

All decisions are taken at the sample strobe, so a sample never changes part-way through a period. The hold input is watched on every clock cycle. A pulse anywhere inside a sample period marks the whole period as held. A saturating counter counts consecutive held periods. When this count exceeds a parameterised threshold (15 by default), auto-mute fires, unless it has been disabled. A mute flag taken in this way is cleared in one of two ways, chosen by a select input.

Top module: `audio_hold_mute`

## Requirements
- R1: In a held period, the strobe drives out_left/out_right with the last pair captured in a non-held period, however many held periods follow one another.
- R2: hold_in at 1 in any single clock cycle between two strobes, or on the strobe cycle itself, makes the period that ends at that strobe a held period.
- R3: Samples presented at the strobe of a held period are discarded: they never reach the outputs, and they do not replace the stored pair.
- R4: With automute_off = 0, the strobe that ends the 16th consecutive held period (the held-period count exceeds 15) sets mute_out to 1. The 15 strobes before it leave mute_out at 0.
- R5: With automute_off = 1, no run of held periods sets mute_out, whatever its length.
- R6: With stay_muted = 0, the first non-held strobe after an auto-mute clears mute_out and outputs the new samples.
- R7: With stay_muted = 1, an auto-mute persists through non-held strobes. It is cleared only once sw_mute has been sampled at 1 on a non-held strobe. A later strobe with sw_mute = 0 then unmutes.
- R8: sw_mute sampled at 1 on any strobe sets mute_out at that strobe, whether or not the period is held.
- R9: While mute_out is 1, both outputs are zero. The outputs and mute_out change only on a strobe cycle. After reset, all of them are 0.
- R10: A non-held strobe returns the held-period count to zero, so two held runs of 10 periods separated by one valid period do not mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking the end of a stereo sample period |
| in_left | input | W | Left input sample, taken at the strobe |
| in_right | input | W | Right input sample, taken at the strobe |
| hold_in | input | 1 | Source flags its data as invalid |
| automute_off | input | 1 | 1 disables auto-mute on long holds |
| stay_muted | input | 1 | 1 keeps an auto-mute active after release until software cycles sw_mute |
| sw_mute | input | 1 | Software mute, sampled at the strobe |
| out_left | output | W | Left output sample |
| out_right | output | W | Right output sample |
| mute_out | output | 1 | Mute status; the outputs are zero while it is 1 |

## Verification
The hardest state to reach is the boundary of the auto-mute. The 15th and the 16th consecutive held strobes must be told apart, and with stay_muted set the mute must then be released in the correct order. The bench drives exact counts of held periods through a per-period task. Each period is held either for its whole length or by a single early pulse. The bench checks every strobe of the run, so an off-by-one shows up at the exact strobe where it occurs. Release is then exercised by non-held periods first with sw_mute low, then high, then low again.

// File: rtl/ahm_pkg.sv
package ahm_pkg;
   // one saturating step of an unsigned counter
   function automatic int unsigned sat_step(input int unsigned v, input int unsigned lim);
      return (v >= lim) ? lim : v + 1;
   endfunction

   typedef enum logic [1:0] {
      REL_AUTO = 2'd0,
      REL_SW   = 2'd1
   } release_mode_e;
endpackage

// File: rtl/ahm_hold_detect.sv
module ahm_hold_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic hold_in,
   output logic held
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seen_q <= 1'b0;
      else if (stb) seen_q <= 1'b0;
      else          seen_q <= seen_q | hold_in;
   end

   assign held = seen_q | hold_in;
endmodule

// File: rtl/ahm_hold_counter.sv
module ahm_hold_counter #(
   parameter int unsigned THRESH = 15,
   parameter int unsigned CW     = $clog2(THRESH + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic          held,
   output logic [CW-1:0] cnt,
   output logic          trig
);
   import ahm_pkg::*;
   localparam int unsigned LIMIT = THRESH + 1;

   logic [CW-1:0] cnt_next;

   always_comb begin
      if (held) cnt_next = CW'(sat_step(32'(cnt), LIMIT));
      else      cnt_next = '0;
      trig = held && (cnt_next > CW'(THRESH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (stb) cnt <= cnt_next;
   end
endmodule

// File: rtl/ahm_mute_ctrl.sv
module ahm_mute_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic held,
   input  logic trig,
   input  logic automute_off,
   input  logic stay_muted,
   input  logic sw_mute,
   output logic mute_next,
   output logic mute_q
);
   import ahm_pkg::*;

   logic          auto_q;
   logic          auto_next;
   release_mode_e rel_mode;

   assign rel_mode = stay_muted ? REL_SW : REL_AUTO;

   always_comb begin
      if (held) begin
         auto_next = auto_q | (trig & ~automute_off);
      end else begin
         unique case (rel_mode)
            REL_SW:  auto_next = auto_q & ~sw_mute;
            default: auto_next = 1'b0;
         endcase
      end
      mute_next = sw_mute | auto_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_q <= 1'b0;
         mute_q <= 1'b0;
      end else if (stb) begin
         auto_q <= auto_next;
         mute_q <= mute_next;
      end
   end
endmodule

// File: rtl/ahm_sample_lane.sv
module ahm_sample_lane #(
   parameter int unsigned W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic         held,
   input  logic         mute_next,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         dout   <= '0;
      end else if (stb) begin
         if (!held) last_q <= din;
         if (mute_next)  dout <= '0;
         else if (held)  dout <= last_q;
         else            dout <= din;
      end
   end
endmodule

// File: rtl/audio_hold_mute.sv
module audio_hold_mute #(
   parameter int unsigned W      = 20,
   parameter int unsigned THRESH = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_stb,
   input  logic [W-1:0] in_left,
   input  logic [W-1:0] in_right,
   input  logic         hold_in,
   input  logic         automute_off,
   input  logic         stay_muted,
   input  logic         sw_mute,
   output logic [W-1:0] out_left,
   output logic [W-1:0] out_right,
   output logic         mute_out
);
   localparam int unsigned NCH   = 2;
   localparam int unsigned LIMIT = THRESH + 1;
   localparam int unsigned CW    = $clog2(THRESH + 2);

   generate
      if (W < 2) begin : g_bad_w
         $error("audio_hold_mute: W must be at least 2");
      end
      if (THRESH < 1) begin : g_bad_t
         $error("audio_hold_mute: THRESH must be at least 1");
      end
   endgenerate

   logic          period_held;
   logic [CW-1:0] hold_cnt;
   logic          am_trig;
   logic          mute_nx;
   logic [W-1:0]  lane_in  [NCH];
   logic [W-1:0]  lane_out [NCH];

   ahm_hold_detect i_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (smp_stb),
      .hold_in (hold_in),
      .held    (period_held)
   );

   ahm_hold_counter #(.THRESH(THRESH), .CW(CW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (smp_stb),
      .held  (period_held),
      .cnt   (hold_cnt),
      .trig  (am_trig)
   );

   ahm_mute_ctrl i_mute (
      .clk          (clk),
      .rst_n        (rst_n),
      .stb          (smp_stb),
      .held         (period_held),
      .trig         (am_trig),
      .automute_off (automute_off),
      .stay_muted   (stay_muted),
      .sw_mute      (sw_mute),
      .mute_next    (mute_nx),
      .mute_q       (mute_out)
   );

   assign lane_in[0] = in_left;
   assign lane_in[1] = in_right;

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      ahm_sample_lane #(.W(W)) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .stb       (smp_stb),
         .held      (period_held),
         .mute_next (mute_nx),
         .din       (lane_in[c]),
         .dout      (lane_out[c])
      );
   end

   assign out_left  = lane_out[0];
   assign out_right = lane_out[1];
endmodule

// File: rtl/ahm_checker.sv
module ahm_checker #(
   parameter int unsigned W     = 20,
   parameter int unsigned CW    = 5,
   parameter int unsigned LIMIT = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_stb,
   input logic          held,
   input logic          stay_muted,
   input logic          sw_mute,
   input logic [CW-1:0] cnt,
   input logic [W-1:0]  out_left,
   input logic [W-1:0]  out_right,
   input logic          mute_out
);
   // R9: muted outputs are zero
   a_r9_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mute_out |-> (out_left == '0 && out_right == '0));

   // R9: outputs move only on a strobe
   a_r9_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> ($stable(out_left) && $stable(out_right) && $stable(mute_out)));

   // R8: software mute takes effect at the strobe
   a_r8_sw_forces: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && sw_mute) |=> mute_out);

   // R6: automatic release on a valid period
   a_r6_auto_release: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !held && !stay_muted && !sw_mute) |=> !mute_out);

   // R10: a valid period clears the held count
   a_r10_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !held) |=> (cnt == '0));

   // R4: count stays within its saturation limit
   a_r4_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT));
endmodule

bind audio_hold_mute ahm_checker #(.W(W), .CW(CW), .LIMIT(LIMIT)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .held       (period_held),
   .stay_muted (stay_muted),
   .sw_mute    (sw_mute),
   .cnt        (hold_cnt),
   .out_left   (out_left),
   .out_right  (out_right),
   .mute_out   (mute_out)
);

// File: tb/test_audio_hold_mute.sv
module test_audio_hold_mute;
   localparam int W = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_stb = 1'b0;
   logic [W-1:0] in_left = '0;
   logic [W-1:0] in_right = '0;
   logic         hold_in = 1'b0;
   logic         automute_off = 1'b0;
   logic         stay_muted = 1'b0;
   logic         sw_mute = 1'b0;
   logic [W-1:0] out_left;
   logic [W-1:0] out_right;
   logic         mute_out;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   audio_hold_mute #(.W(W), .THRESH(15)) i_audio_hold_mute (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
      .in_left(in_left), .in_right(in_right), .hold_in(hold_in),
      .automute_off(automute_off), .stay_muted(stay_muted), .sw_mute(sw_mute),
      .out_left(out_left), .out_right(out_right), .mute_out(mute_out)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // hm: 0 = no hold, 1 = single pulse at period start, 2 = hold whole period
   task automatic period(input logic [W-1:0] l, input logic [W-1:0] r, input int hm,
                         input logic sw, input logic [W-1:0] el, input logic [W-1:0] er,
                         input logic em, input string req);
      logic [W-1:0] pl = out_left;
      logic         pm = mute_out;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i == 2) begin
            check({req, " R9 stable left"}, out_left, pl);
            check({req, " R9 stable mute"}, W'(mute_out), W'(pm));
         end
         smp_stb  = (i == 3);
         hold_in  = (hm == 2) || (hm == 1 && i == 0);
         in_left  = l;
         in_right = r;
         sw_mute  = sw;
      end
      @(negedge clk);
      smp_stb = 1'b0;
      hold_in = 1'b0;
      check({req, " left"}, out_left, el);
      check({req, " right"}, out_right, er);
      check({req, " mute"}, W'(mute_out), W'(em));
   endtask

   task automatic t_reset();
      check("R9 reset left", out_left, '0);
      check("R9 reset right", out_right, '0);
      check("R9 reset mute", W'(mute_out), '0);
   endtask

   task automatic t_hold_basic();
      period(20'h11111, 20'h22222, 0, 0, 20'h11111, 20'h22222, 0, "R1 pass");
      for (int k = 0; k < 3; k++)
         period(20'hAAA00 + W'(k), 20'hBBB00 + W'(k), 2, 0, 20'h11111, 20'h22222, 0, "R1 R3 hold");
      period(20'h33333, 20'h44444, 0, 0, 20'h33333, 20'h44444, 0, "R3 release new");
      period(20'h55555, 20'h66666, 1, 0, 20'h33333, 20'h44444, 0, "R2 pulse hold");
      period(20'h77777, 20'h88888, 0, 0, 20'h77777, 20'h88888, 0, "R3 after pulse");
   endtask

   task automatic t_automute();
      period(20'h0ABCD, 20'h0DCBA, 0, 0, 20'h0ABCD, 20'h0DCBA, 0, "R4 prime");
      for (int k = 1; k <= 15; k++)
         period(20'hF0000, 20'hF0001, 2, 0, 20'h0ABCD, 20'h0DCBA, 0, "R4 below threshold");
      period(20'hF0000, 20'hF0001, 2, 0, '0, '0, 1, "R4 16th held mutes");
      period(20'hF0000, 20'hF0001, 2, 0, '0, '0, 1, "R4 still muted");
      period(20'h12345, 20'h54321, 0, 0, 20'h12345, 20'h54321, 0, "R6 auto unmute");
   endtask

   task automatic t_disabled();
      automute_off = 1'b1;
      for (int k = 0; k < 20; k++)
         period(20'hEEEEE, 20'hDDDDD, 2, 0, 20'h12345, 20'h54321, 0, "R5 no automute");
      period(20'h00042, 20'h00024, 0, 0, 20'h00042, 20'h00024, 0, "R5 release");
      automute_off = 1'b0;
   endtask

   task automatic t_count_reset();
      for (int k = 0; k < 10; k++)
         period(20'h99999, 20'h99999, 2, 0, 20'h00042, 20'h00024, 0, "R10 run one");
      period(20'h00100, 20'h00200, 0, 0, 20'h00100, 20'h00200, 0, "R10 gap");
      for (int k = 0; k < 10; k++)
         period(20'h99999, 20'h99999, 2, 0, 20'h00100, 20'h00200, 0, "R10 run two");
      period(20'h00300, 20'h00400, 0, 0, 20'h00300, 20'h00400, 0, "R10 end");
   endtask

   task automatic t_stay_muted();
      stay_muted = 1'b1;
      for (int k = 0; k < 15; k++)
         period(20'h0F0F0, 20'h0F0F0, 2, 0, 20'h00300, 20'h00400, 0, "R7 hold");
      period(20'h0F0F0, 20'h0F0F0, 2, 0, '0, '0, 1, "R7 automute");
      for (int k = 0; k < 3; k++)
         period(20'h00500, 20'h00600, 0, 0, '0, '0, 1, "R7 stays muted");
      period(20'h00700, 20'h00800, 0, 1, '0, '0, 1, "R7 sw mute");
      period(20'h00900, 20'h00A00, 0, 0, 20'h00900, 20'h00A00, 0, "R7 sw unmute");
      stay_muted = 1'b0;
   endtask

   task automatic t_sw_mute();
      period(20'h01000, 20'h02000, 0, 1, '0, '0, 1, "R8 sw mute valid");
      period(20'h03000, 20'h04000, 2, 1, '0, '0, 1, "R8 sw mute held");
      period(20'h05000, 20'h06000, 0, 0, 20'h05000, 20'h06000, 0, "R8 release");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_hold_basic();
      t_automute();
      t_disabled();
      t_count_reset();
      t_stay_muted();
      t_sw_mute();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule